// File: doc/BRIEF.md
# Multi-Source Interrupt Aggregation Controller

This block merges interrupt requests from several parallel-port channels and a set of timer outputs onto a single level-sensitive host request line. Each port channel has an A side and a B side. A side can request an interrupt in three ways, depending on its configured mode:

- through a single-handshake flag;
- through the OR of its output-transfer and input-transfer flags in bidirectional mode;
- through an external pin in simple I/O mode.

The B side can request either through its handshake flag or through a second external pin in simple I/O mode. The external pins count only when the low nibble of the channel's port C is set as an input.

Software controls the block through a small register interface. The control register holds a master enable. The enable register holds, for each channel, one handshake enable and two external-pin enables, followed by one enable per timer. Gating works as follows:

- Every source is ANDed with its own enable bit and with the master enable.
- The OR of all gated sources is registered once and drives the host line.
- A read-only status register shows the gated sources.

Requests are not latched. A source must stay active until software services it.

Top module: `irq_aggregator`

## Requirements
- R1: While the master enable (control register, address 0, bit 0) is clear, every status bit reads 0 and the host line is low.
- R2: When channel p's A side is in handshake mode (A mode code 1), its handshake flag sets status bit 2p, but only while enable bit 3p (the channel enable) is set.
- R3: When channel p's B side is in handshake mode (B mode code 1), its handshake flag sets status bit 2p+1 under the same channel enable 3p, independently of the A side.
- R4: When channel p's A side is in bidirectional mode (A mode code 2 or 3), the OR of its output-transfer and input-transfer flags sets status bit 2p under channel enable 3p.
- R5: When channel p's A side is in simple I/O mode (code 0) and its low nibble is an input, the high-side external pin sets status bit 2p under enable bit 3p+1; in any other A mode that pin is ignored.
- R6: When channel p's B side is in simple I/O mode (code 0) and its low nibble is an input, the low-side external pin sets status bit 2p+1 under enable bit 3p+2; with the nibble set as output the pin is ignored.
- R7: Requests are level-based: the host line drops after its only active source goes low, with no latching.
- R8: Timer t sets status bit 2P+t under enable bit 3P+t (P = number of channels).
- R9: Clearing a source's enable bit or the master enable removes that source's request at once: the status bit clears in the cycle after the write edge, and the host line on the next edge.
- R10: The status register (address 2) is read-only; writes to addresses 2 and 3 change nothing, and address 3 reads 0.
- R11: The host line is the OR of all status bits, registered: it changes one clock edge after the status changes.
- R12: After reset the control register, the enable register and the status register read 0, and the host line is low.
- R13: The control and enable registers (addresses 0 and 1) read back the values last written; the control register keeps only bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address (0 control, 1 enable, 2 status) |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| port_a_mode | input | 2*NUM_PORTS | Per-channel A-side mode code, 2 bits each |
| port_b_mode | input | NUM_PORTS | Per-channel B side: 1 handshake, 0 simple I/O |
| low_c_in | input | NUM_PORTS | Low nibble of port C configured as input |
| a_hs_flag | input | NUM_PORTS | A-side single-handshake interrupt flag |
| a_out_flag | input | NUM_PORTS | A-side bidirectional output-transfer flag |
| a_in_flag | input | NUM_PORTS | A-side bidirectional input-transfer flag |
| b_hs_flag | input | NUM_PORTS | B-side handshake interrupt flag |
| ext_pin_hi | input | NUM_PORTS | External pin serving the A side in simple I/O mode |
| ext_pin_lo | input | NUM_PORTS | External pin serving the B side in simple I/O mode |
| timer_out | input | NUM_TIMERS | Timer output requests |
| host_irq | output | 1 | Registered level-sensitive host request |

## Verification
The bench drives an external pin high while the A side is in handshake mode. A design that ignored the mode would raise a spurious request. It also flips the low nibble of port C to output with a pin still high, where a design that skipped the direction check would keep requesting. In bidirectional mode each transfer flag is raised on its own, which exposes a design that wires only one of them. Further checks cover the following:

- The host line must fall as soon as a source drops, because a latched design would hold it.
- Clearing the master enable or a single enable bit while a source is active must cut the request.
- A write to the status address must leave every register unchanged.
- The host line is sampled before and after the first clock edge, to catch a design that is not registered or is one cycle late.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

   typedef enum logic [1:0] {
      AMODE_SIMPLE    = 2'd0,
      AMODE_HANDSHAKE = 2'd1,
      AMODE_BIDIR     = 2'd2,
      AMODE_BIDIR_ALT = 2'd3
   } amode_e;

   localparam int unsigned EN_PER_PORT   = 3;
   localparam int unsigned STAT_PER_PORT = 2;

   localparam logic [1:0] ADDR_CTRL   = 2'd0;
   localparam logic [1:0] ADDR_ENABLE = 2'd1;
   localparam logic [1:0] ADDR_STATUS = 2'd2;

   function automatic int unsigned en_width(int unsigned np, int unsigned nt);
      return EN_PER_PORT * np + nt;
   endfunction

   function automatic int unsigned stat_width(int unsigned np, int unsigned nt);
      return STAT_PER_PORT * np + nt;
   endfunction

endpackage

// File: rtl/irq_agg_regs.sv
module irq_agg_regs
   import irq_agg_pkg::*;
#(
   parameter int unsigned DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [1:0]        addr,
   input  logic [DATA_W-1:0] wdata,
   output logic              master_en,
   output logic [DATA_W-1:0] enable_q
);

   logic wr_ctrl;
   logic wr_enable;

   assign wr_ctrl   = wr && (addr == ADDR_CTRL);
   assign wr_enable = wr && (addr == ADDR_ENABLE);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         master_en <= 1'b0;
      end else if (wr_ctrl) begin
         master_en <= wdata[0];
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         enable_q <= '0;
      end else if (wr_enable) begin
         enable_q <= wdata;
      end
   end

endmodule

// File: rtl/irq_agg_port_sel.sv
module irq_agg_port_sel
   import irq_agg_pkg::*;
(
   input  logic [1:0] a_mode,
   input  logic       b_mode,
   input  logic       low_nib_in,
   input  logic       a_hs,
   input  logic       a_out,
   input  logic       a_in,
   input  logic       b_hs,
   input  logic       pin_hi,
   input  logic       pin_lo,
   input  logic       en_chan,
   input  logic       en_pin_hi,
   input  logic       en_pin_lo,
   input  logic       master_en,
   output logic       req_a,
   output logic       req_b
);

   logic raw_a;
   logic raw_b;
   amode_e mode_a;

   assign mode_a = amode_e'(a_mode);

   // A side: the source depends on the configured mode
   always_comb begin
      unique case (mode_a)
         AMODE_SIMPLE:    raw_a = pin_hi && low_nib_in && en_pin_hi;
         AMODE_HANDSHAKE: raw_a = a_hs && en_chan;
         AMODE_BIDIR,
         AMODE_BIDIR_ALT: raw_a = (a_out || a_in) && en_chan;
         default:         raw_a = 1'b0;
      endcase
   end

   // B side: handshake flag, or the low-side pin in simple I/O mode
   always_comb begin
      if (b_mode) begin
         raw_b = b_hs && en_chan;
      end else begin
         raw_b = pin_lo && low_nib_in && en_pin_lo;
      end
   end

   assign req_a = raw_a && master_en;
   assign req_b = raw_b && master_en;

endmodule

// File: rtl/irq_agg_out.sv
module irq_agg_out #(
   parameter int unsigned SRC_W = 11
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SRC_W-1:0] src,
   output logic             irq
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq <= 1'b0;
      end else begin
         irq <= |src;
      end
   end

endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
   import irq_agg_pkg::*;
#(
   parameter int unsigned NUM_PORTS  = 4,
   parameter int unsigned NUM_TIMERS = 3,
   parameter int unsigned DATA_W     = 16
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    reg_wr,
   input  logic [1:0]              reg_addr,
   input  logic [DATA_W-1:0]       reg_wdata,
   output logic [DATA_W-1:0]       reg_rdata,
   input  logic [2*NUM_PORTS-1:0]  port_a_mode,
   input  logic [NUM_PORTS-1:0]    port_b_mode,
   input  logic [NUM_PORTS-1:0]    low_c_in,
   input  logic [NUM_PORTS-1:0]    a_hs_flag,
   input  logic [NUM_PORTS-1:0]    a_out_flag,
   input  logic [NUM_PORTS-1:0]    a_in_flag,
   input  logic [NUM_PORTS-1:0]    b_hs_flag,
   input  logic [NUM_PORTS-1:0]    ext_pin_hi,
   input  logic [NUM_PORTS-1:0]    ext_pin_lo,
   input  logic [NUM_TIMERS-1:0]   timer_out,
   output logic                    host_irq
);

   localparam int unsigned EN_W   = en_width(NUM_PORTS, NUM_TIMERS);
   localparam int unsigned STAT_W = stat_width(NUM_PORTS, NUM_TIMERS);
   localparam int unsigned TMR_EN_BASE = EN_PER_PORT * NUM_PORTS;
   localparam int unsigned TMR_ST_BASE = STAT_PER_PORT * NUM_PORTS;

   if (NUM_PORTS < 1) begin : g_chk_ports
      $error("irq_aggregator: NUM_PORTS must be at least 1");
   end
   if (NUM_TIMERS < 1) begin : g_chk_timers
      $error("irq_aggregator: NUM_TIMERS must be at least 1");
   end
   if (DATA_W < EN_W) begin : g_chk_width
      $error("irq_aggregator: DATA_W too narrow for the enable register");
   end

   logic              master_en;
   logic [DATA_W-1:0] enable_q;
   logic [STAT_W-1:0] status_vec;
   logic [NUM_TIMERS-1:0] timer_en;

   irq_agg_regs #(.DATA_W(DATA_W)) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr        (reg_wr),
      .addr      (reg_addr),
      .wdata     (reg_wdata),
      .master_en (master_en),
      .enable_q  (enable_q)
   );

   for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
      irq_agg_port_sel u_sel (
         .a_mode     (port_a_mode[2*p +: 2]),
         .b_mode     (port_b_mode[p]),
         .low_nib_in (low_c_in[p]),
         .a_hs       (a_hs_flag[p]),
         .a_out      (a_out_flag[p]),
         .a_in       (a_in_flag[p]),
         .b_hs       (b_hs_flag[p]),
         .pin_hi     (ext_pin_hi[p]),
         .pin_lo     (ext_pin_lo[p]),
         .en_chan    (enable_q[EN_PER_PORT*p]),
         .en_pin_hi  (enable_q[EN_PER_PORT*p + 1]),
         .en_pin_lo  (enable_q[EN_PER_PORT*p + 2]),
         .master_en  (master_en),
         .req_a      (status_vec[STAT_PER_PORT*p]),
         .req_b      (status_vec[STAT_PER_PORT*p + 1])
      );
   end

   assign timer_en = enable_q[TMR_EN_BASE +: NUM_TIMERS];

   for (genvar t = 0; t < NUM_TIMERS; t++) begin : g_tmr
      assign status_vec[TMR_ST_BASE + t] = timer_out[t] && timer_en[t] && master_en;
   end

   irq_agg_out #(.SRC_W(STAT_W)) u_out (
      .clk   (clk),
      .rst_n (rst_n),
      .src   (status_vec),
      .irq   (host_irq)
   );

   always_comb begin
      reg_rdata = '0;
      unique case (reg_addr)
         ADDR_CTRL:   reg_rdata[0] = master_en;
         ADDR_ENABLE: reg_rdata = enable_q;
         ADDR_STATUS: reg_rdata[STAT_W-1:0] = status_vec;
         default:     reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/irq_agg_chk.sv
module irq_agg_chk #(
   parameter int unsigned NP = 4,
   parameter int unsigned NT = 3
) (
   input logic              clk,
   input logic              rst_n,
   input logic              master_en,
   input logic [2*NP+NT-1:0] status_vec,
   input logic              host_irq,
   input logic [NT-1:0]     timer_out,
   input logic [2*NP-1:0]   port_a_mode,
   input logic [NP-1:0]     port_b_mode,
   input logic [NP-1:0]     low_c_in,
   input logic [NP-1:0]     ext_pin_hi,
   input logic [NP-1:0]     ext_pin_lo,
   input logic [NP-1:0]     a_out_flag,
   input logic [NP-1:0]     a_in_flag
);

   AST_MASTER_GATE: assert property (@(posedge clk) disable iff (!rst_n)
      !master_en |=> !host_irq); // R1

   AST_IRQ_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (host_irq == $past(|status_vec))); // R11

   for (genvar t = 0; t < NT; t++) begin : g_t
      AST_TIMER_SRC: assert property (@(posedge clk) disable iff (!rst_n)
         status_vec[2*NP + t] |-> timer_out[t]); // R8
   end

   for (genvar p = 0; p < NP; p++) begin : g_p
      AST_BIDIR_SRC: assert property (@(posedge clk) disable iff (!rst_n)
         (status_vec[2*p] && port_a_mode[2*p+1]) |-> (a_out_flag[p] || a_in_flag[p])); // R4
      AST_EXT_HI_SRC: assert property (@(posedge clk) disable iff (!rst_n)
         (status_vec[2*p] && (port_a_mode[2*p +: 2] == 2'd0)) |-> (ext_pin_hi[p] && low_c_in[p])); // R5
      AST_EXT_LO_SRC: assert property (@(posedge clk) disable iff (!rst_n)
         (status_vec[2*p+1] && !port_b_mode[p]) |-> (ext_pin_lo[p] && low_c_in[p])); // R6
   end

endmodule

bind irq_aggregator irq_agg_chk #(.NP(NUM_PORTS), .NT(NUM_TIMERS)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .master_en   (master_en),
   .status_vec  (status_vec),
   .host_irq    (host_irq),
   .timer_out   (timer_out),
   .port_a_mode (port_a_mode),
   .port_b_mode (port_b_mode),
   .low_c_in    (low_c_in),
   .ext_pin_hi  (ext_pin_hi),
   .ext_pin_lo  (ext_pin_lo),
   .a_out_flag  (a_out_flag),
   .a_in_flag   (a_in_flag)
);

// File: tb/tb_irq_aggregator.sv
module tb_irq_aggregator;

   localparam int NP = 4;
   localparam int NT = 3;
   localparam int DW = 16;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          reg_wr = 1'b0;
   logic [1:0]    reg_addr = '0;
   logic [DW-1:0] reg_wdata = '0;
   logic [DW-1:0] reg_rdata;
   logic [2*NP-1:0] port_a_mode = '0;
   logic [NP-1:0] port_b_mode = '0;
   logic [NP-1:0] low_c_in = '0;
   logic [NP-1:0] a_hs_flag = '0;
   logic [NP-1:0] a_out_flag = '0;
   logic [NP-1:0] a_in_flag = '0;
   logic [NP-1:0] b_hs_flag = '0;
   logic [NP-1:0] ext_pin_hi = '0;
   logic [NP-1:0] ext_pin_lo = '0;
   logic [NT-1:0] timer_out = '0;
   logic          host_irq;

   int n_checks = 0;
   int n_fail = 0;

   always #5 clk = ~clk;

   irq_aggregator #(.NUM_PORTS(NP), .NUM_TIMERS(NT), .DATA_W(DW)) dut (
      .clk, .rst_n, .reg_wr, .reg_addr, .reg_wdata, .reg_rdata,
      .port_a_mode, .port_b_mode, .low_c_in, .a_hs_flag, .a_out_flag,
      .a_in_flag, .b_hs_flag, .ext_pin_hi, .ext_pin_lo, .timer_out, .host_irq
   );

   task automatic check(string req, logic [31:0] act, logic [31:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [DW-1:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(logic [1:0] a, output logic [DW-1:0] d);
      reg_addr = a;
      #1;
      d = reg_rdata;
   endtask

   task automatic settle();
      repeat (2) @(negedge clk);
   endtask

   task automatic clear_inputs();
      @(negedge clk);
      port_a_mode = '0; port_b_mode = '0; low_c_in = '0;
      a_hs_flag = '0; a_out_flag = '0; a_in_flag = '0; b_hs_flag = '0;
      ext_pin_hi = '0; ext_pin_lo = '0; timer_out = '0;
      wr(2'd1, '0);
      settle();
   endtask

   task automatic t_reset();
      logic [DW-1:0] d;
      rd(2'd0, d); check("R12 ctrl after reset", d, 0);
      rd(2'd1, d); check("R12 enable after reset", d, 0);
      rd(2'd2, d); check("R12 status after reset", d, 0);
      check("R12 host_irq after reset", host_irq, 0);
   endtask

   task automatic t_master_gate();
      logic [DW-1:0] d;
      wr(2'd1, 16'h7FFF);
      rd(2'd1, d); check("R13 enable readback", d, 16'h7FFF);
      timer_out = 3'b111;
      settle();
      rd(2'd2, d); check("R1 status with master off", d, 0);
      check("R1 host_irq with master off", host_irq, 0);
      wr(2'd0, 16'hFFFF);
      rd(2'd0, d); check("R13 ctrl keeps bit 0 only", d, 1);
      settle();
      rd(2'd2, d); check("R8 all timers active", d, 16'h0700);
      check("R1 host_irq with master on", host_irq, 1);
      wr(2'd0, 16'h0000);
      rd(2'd2, d); check("R9 status cleared by master off", d, 0);
      @(negedge clk);
      check("R9 host_irq after master off", host_irq, 0);
      wr(2'd0, 16'h0001);
      clear_inputs();
   endtask

   task automatic t_handshake();
      logic [DW-1:0] d;
      port_a_mode = 8'b00_01_01_00;  // channels 1 and 2 in A handshake
      port_b_mode = 4'b0010;
      a_hs_flag = 4'b0110;
      wr(2'd1, 16'h0008);            // channel 1 enable only
      settle();
      rd(2'd2, d); check("R2 port1 A handshake", d, 16'h0004);
      b_hs_flag = 4'b0010;
      settle();
      rd(2'd2, d); check("R3 port1 B handshake independent", d, 16'h000C);
      check("R2 host_irq", host_irq, 1);
      a_hs_flag = 4'b0100;
      settle();
      rd(2'd2, d); check("R3 B alone after A drops", d, 16'h0008);
      clear_inputs();
   endtask

   task automatic t_bidir();
      logic [DW-1:0] d;
      port_a_mode = 8'b00_00_00_10;
      wr(2'd1, 16'h0001);
      a_out_flag = 4'b0001;
      settle();
      rd(2'd2, d); check("R4 bidir output flag", d, 16'h0001);
      a_out_flag = 4'b0000; a_in_flag = 4'b0001;
      settle();
      rd(2'd2, d); check("R4 bidir input flag", d, 16'h0001);
      port_a_mode = 8'b00_00_00_11;
      settle();
      rd(2'd2, d); check("R4 bidir alternate code", d, 16'h0001);
      a_in_flag = 4'b0000;
      settle();
      rd(2'd2, d); check("R4 bidir no flags", d, 0);
      check("R7 host_irq drops with source", host_irq, 0);
      clear_inputs();
   endtask

   task automatic t_ext_pins();
      logic [DW-1:0] d;
      low_c_in = 4'b1000;
      wr(2'd1, 16'h0C00);            // channel 3 pin enables, bits 10 and 11
      ext_pin_hi = 4'b1000;
      settle();
      rd(2'd2, d); check("R5 high pin in simple mode", d, 16'h0040);
      ext_pin_lo = 4'b1000;
      settle();
      rd(2'd2, d); check("R6 low pin in simple mode", d, 16'h00C0);
      ext_pin_hi = 4'b0000;
      settle();
      rd(2'd2, d); check("R7 level follows pin", d, 16'h0080);
      ext_pin_lo = 4'b0000;
      settle();
      check("R7 host_irq low after pin falls", host_irq, 0);
      ext_pin_hi = 4'b1000; ext_pin_lo = 4'b1000; low_c_in = 4'b0000;
      settle();
      rd(2'd2, d); check("R6 pins ignored with nibble as output", d, 0);
      low_c_in = 4'b1000; ext_pin_lo = 4'b0000;
      port_a_mode = 8'b01_00_00_00;  // channel 3 A handshake, flag low
      settle();
      rd(2'd2, d); check("R5 high pin ignored in handshake mode", d, 0);
      check("R5 host_irq stays low", host_irq, 0);
      clear_inputs();
   endtask

   task automatic t_timer_and_timing();
      logic [DW-1:0] d;
      wr(2'd1, 16'h4000);            // timer 2 enable
      settle();
      @(negedge clk);
      timer_out = 3'b100;
      #1;
      check("R11 host_irq not yet set before edge", host_irq, 0);
      rd(2'd2, d); check("R8 timer 2 status", d, 16'h0400);
      @(negedge clk);
      check("R11 host_irq one edge later", host_irq, 1);
      timer_out = 3'b011;
      settle();
      rd(2'd2, d); check("R8 disabled timers ignored", d, 0);
      timer_out = 3'b100;
      settle();
      wr(2'd1, 16'h0000);
      rd(2'd2, d); check("R9 status off after enable cleared", d, 0);
      @(negedge clk);
      check("R9 host_irq off after enable cleared", host_irq, 0);
      clear_inputs();
   endtask

   task automatic t_readonly();
      logic [DW-1:0] d;
      wr(2'd1, 16'h1000);
      timer_out = 3'b001;
      settle();
      wr(2'd2, 16'h0000);
      wr(2'd3, 16'h0000);
      rd(2'd2, d); check("R10 status after write attempt", d, 16'h0100);
      rd(2'd1, d); check("R10 enable untouched", d, 16'h1000);
      rd(2'd0, d); check("R10 ctrl untouched", d, 1);
      rd(2'd3, d); check("R10 address 3 reads zero", d, 0);
      check("R10 host_irq still set", host_irq, 1);
      clear_inputs();
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_master_gate();
      t_handshake();
      t_bidir();
      t_ext_pins();
      t_timer_and_timing();
      t_readonly();
      $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
      $finish;
   end

endmodule